// File: doc/BRIEF.md
# Byte-Wide UV EPROM Emulator

This block stands in for an ultraviolet-erasable, byte-wide read-only memory inside simulation models and FPGA test rigs. It keeps a parameterised byte array and reacts to the same control pattern as the real part. The controls are an active-low chip-enable/program strobe, an active-low output enable, and two digital flags. The first flag reports that the programming supply sits at its high level. The second reports that address bit 9 carries the signature voltage. Analog levels, true access times and the optics of erasure are not modelled. A synchronous erase input returns the whole array to the blank state in a single clock.

All inputs are sampled on the rising clock edge, and the outputs are registered. Read data appears two clock edges after the inputs that select it. A program pulse can only clear bits. The stored byte becomes the old byte ANDed with the applied data. A pulse is accepted only when it starts with a falling edge of the strobe in program mode and ends with a rising edge within `MAX_PW` low cycles. The block flags misuse, such as a strobe held low while the supply is raised or an overlong pulse, on a sticky error output.

Top module: `eprom_emu`

## Requirements
- R1: Outputs are enabled (`dout_en`=1) only in read (hv_on=0, ce_n=0, oe_n=0) and verify (hv_on=1, oe_n=0). In standby (hv_on=0, ce_n=1), output disable (hv_on=0, ce_n=0, oe_n=1), program (hv_on=1, ce_n=0, oe_n=1) and program inhibit (hv_on=1, ce_n=1, oe_n=1), `dout_en` is 0 and `dout` is 0x00.
- R2: After reset or after a one-cycle `erase` pulse, every address reads 0xFF.
- R3: A pulse that starts with a falling `ce_n` while in program mode and ends with `ce_n` rising while `hv_on`=1 and `oe_n`=1 sets the byte at `addr` to old AND `din`.
- R4: A program pulse never turns a 0 bit back to 1. Only erase restores ones.
- R5: In verify mode the stored byte is driven on `dout`, whatever the level of `ce_n`.
- R6: In program inhibit (ce_n held high), the array is left unchanged.
- R7: In read mode with `sig_a9`=1, `dout` is 0x8F when addr[0]=0 and 0x08 when addr[0]=1, regardless of the array contents and of the other address bits.
- R8: If `hv_on` rises while `ce_n` is low, `err` is set and that low period writes nothing.
- R9: A pulse of up to `MAX_PW` low cycles is accepted. A longer one sets `err` and writes nothing.
- R10: `err` stays set until reset.
- R11: A change of `addr` in read mode shows on `dout` after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also blanks the array |
| addr | input | AW | Byte address |
| ce_n | input | 1 | Chip enable / program strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| hv_on | input | 1 | Programming supply at high voltage |
| sig_a9 | input | 1 | Address bit 9 at signature voltage |
| erase | input | 1 | Blank the whole array in one clock |
| din | input | 8 | Data to program |
| dout | output | 8 | Data out (0x00 when not driven) |
| dout_en | output | 1 | Data outputs driven (low models high impedance) |
| err | output | 1 | Sticky misuse flag |

## Verification
On every cycle, the embedded assertions check four things. The outputs go quiet two edges after standby. Any write coincides with a rising strobe that was low on the previous edge. An armed pulse never counts past its limit. The error flag is raised after a supply rise under a low strobe and then never falls. The scenarios alone show the data behaviour: the AND-only update, the refusal to restore ones, the signature bytes, the exact pulse-width boundary, and erase returning every location to 0xFF. They show these by reading values back through the normal read and verify paths.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;
  typedef enum logic [2:0] {
    M_READ,
    M_OUTDIS,
    M_STANDBY,
    M_PROG,
    M_VERIFY,
    M_INHIBIT
  } mode_e;

  localparam logic [7:0] BLANK_BYTE = 8'hFF;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_emu_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  hv_on,
  output mode_e mode
);
  // High supply selects the programming family of modes; otherwise the
  // strobe has priority over the output enable.
  always_comb begin
    if (hv_on) begin
      if (!oe_n)      mode = M_VERIFY;
      else if (!ce_n) mode = M_PROG;
      else            mode = M_INHIBIT;
    end else begin
      if (ce_n)       mode = M_STANDBY;
      else if (oe_n)  mode = M_OUTDIS;
      else            mode = M_READ;
    end
  end
endmodule

// File: rtl/eprom_pulse_ctl.sv
module eprom_pulse_ctl
  import eprom_emu_pkg::*;
#(
  parameter int MAX_PW = 64
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  hv_on,
  input  mode_e mode,
  output logic  wr_en,
  output logic  err
);
  localparam int CW = $clog2(MAX_PW + 1);

  logic          ce_q;
  logic          hv_q;
  logic          armed;
  logic [CW-1:0] cnt;
  logic          fall, rise;

  assign fall  = ce_q & ~ce_n;
  assign rise  = ~ce_q & ce_n;
  assign wr_en = armed & rise & hv_on & oe_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q  <= 1'b1;
      hv_q  <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
      err   <= 1'b0;
    end else begin
      ce_q <= ce_n;
      hv_q <= hv_on;
      if (hv_on && !hv_q && !ce_n) err <= 1'b1;
      if (armed) begin
        if (rise) begin
          armed <= 1'b0;
        end else if (!hv_on || !oe_n) begin
          armed <= 1'b0;
        end else if (cnt == CW'(MAX_PW)) begin
          armed <= 1'b0;
          err   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fall && mode == M_PROG) begin
        armed <= 1'b1;
        cnt   <= CW'(1);
      end
    end
  end

  AST_HV_RISE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    ($rose(hv_on) && !ce_n) |=> err); // R8

  AST_WRITE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!$past(ce_n) && ce_n)); // R3

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt <= CW'(MAX_PW))); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(err) |-> err); // R10
endmodule

// File: rtl/eprom_store.sv
module eprom_store
  import eprom_emu_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    byte_q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] live;
  logic [7:0]       rd_q;
  logic             live_q;
  logic             do_wr;

  assign do_wr  = wr_en & ~erase;
  assign byte_q = live_q ? rd_q : BLANK_BYTE;

  // Plain synchronous RAM, read-first, no reset: maps onto block RAM.
  always_ff @(posedge clk) begin
    rd_q <= mem[addr];
    if (do_wr) mem[addr] <= byte_q & din;
  end

  // One flag per location; clearing all flags is the one-clock erase.
  always_ff @(posedge clk) begin
    if (rst) begin
      live   <= '0;
      live_q <= 1'b0;
    end else begin
      live_q <= live[addr];
      if (erase)      live       <= '0;
      else if (do_wr) live[addr] <= 1'b1;
    end
  end
endmodule

// File: rtl/eprom_out.sv
module eprom_out
  import eprom_emu_pkg::*;
#(
  parameter logic [7:0] MFR_ID = 8'h8F,
  parameter logic [7:0] DEV_ID = 8'h08
) (
  input  logic       clk,
  input  logic       rst,
  input  mode_e      mode,
  input  logic       sig_a9,
  input  logic       a0,
  input  logic [7:0] byte_q,
  output logic [7:0] dout,
  output logic       dout_en
);
  mode_e m1;
  logic  sig1, a01, drive;

  assign drive = (m1 == M_READ) || (m1 == M_VERIFY);

  always_ff @(posedge clk) begin
    if (rst) begin
      m1      <= M_STANDBY;
      sig1    <= 1'b0;
      a01     <= 1'b0;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      m1      <= mode;
      sig1    <= sig_a9;
      a01     <= a0;
      dout_en <= drive;
      if (!drive)                       dout <= '0;
      else if (sig1 && m1 == M_READ)    dout <= a01 ? DEV_ID : MFR_ID;
      else                              dout <= byte_q;
    end
  end
endmodule

// File: rtl/eprom_emu.sv
module eprom_emu
  import eprom_emu_pkg::*;
#(
  parameter int AW     = 10,
  parameter int MAX_PW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          hv_on,
  input  logic          sig_a9,
  input  logic          erase,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic          err
);
  mode_e      mode;
  logic       wr_en;
  logic [7:0] byte_q;

  eprom_mode_dec u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .hv_on(hv_on), .mode(mode)
  );

  eprom_pulse_ctl #(.MAX_PW(MAX_PW)) u_pulse (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .hv_on(hv_on),
    .mode(mode), .wr_en(wr_en), .err(err)
  );

  eprom_store #(.AW(AW)) u_store (
    .clk(clk), .rst(rst), .erase(erase), .wr_en(wr_en),
    .addr(addr), .din(din), .byte_q(byte_q)
  );

  eprom_out u_out (
    .clk(clk), .rst(rst), .mode(mode), .sig_a9(sig_a9), .a0(addr[0]),
    .byte_q(byte_q), .dout(dout), .dout_en(dout_en)
  );

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(ce_n, 2) && !$past(hv_on, 2)) |-> !dout_en); // R1
endmodule

// File: tb/eprom_emu_tb.sv
module eprom_emu_tb;
  localparam int AW = 10;
  localparam int PW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, hv_on = 1'b0, sig_a9 = 1'b0, erase = 1'b0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          dout_en, err;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  eprom_emu #(.AW(AW), .MAX_PW(PW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .hv_on(hv_on), .sig_a9(sig_a9), .erase(erase), .din(din),
    .dout(dout), .dout_en(dout_en), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; hv_on = 1'b0; sig_a9 = 1'b0; erase = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic c, input logic o, input logic h);
    @(negedge clk);
    ce_n = c; oe_n = o; hv_on = h;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic s, output logic [7:0] d, output logic e);
    @(negedge clk);
    addr = a; sig_a9 = s; hv_on = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    d = dout; e = dout_en;
    sig_a9 = 1'b0;
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] v, input int width);
    @(negedge clk);
    addr = a; din = v; hv_on = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b0;
    repeat (width) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
    hv_on = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(dout_en == 1'b0, "R1 reset dout_en", dout_en, 0);
    chk(err == 1'b0, "R10 reset err", err, 0);
  endtask

  task automatic t_blank();
    logic [7:0] d; logic e;
    rd(10'd5, 1'b0, d, e);
    chk(e && d == 8'hFF, "R2 blank read", d, 8'hFF);
  endtask

  task automatic t_program_and();
    logic [7:0] d; logic e;
    prog(10'd3, 8'h5A, 3);
    rd(10'd3, 1'b0, d, e);
    chk(d == 8'h5A, "R3 first program", d, 8'h5A);
    prog(10'd3, 8'hF0, 2);
    rd(10'd3, 1'b0, d, e);
    chk(d == 8'h50, "R3 AND update", d, 8'h50);
    prog(10'd3, 8'hFF, 1);
    rd(10'd3, 1'b0, d, e);
    chk(d == 8'h50, "R4 ones not restored", d, 8'h50);
    chk(err == 1'b0, "R3 no error on good pulses", err, 0);
  endtask

  task automatic t_latency();
    logic [7:0] d; logic e;
    prog(10'd4, 8'h3C, 1);
    rd(10'd3, 1'b0, d, e);
    addr = 10'd4;
    @(negedge clk);
    chk(dout == 8'h50, "R11 one edge still old", dout, 8'h50);
    @(negedge clk);
    chk(dout == 8'h3C, "R11 two edges new", dout, 8'h3C);
  endtask

  task automatic t_verify();
    @(negedge clk);
    addr = 10'd3;
    set_ctl(1'b1, 1'b0, 1'b1);
    chk(dout_en && dout == 8'h50, "R5 verify ce high", dout, 8'h50);
    set_ctl(1'b0, 1'b0, 1'b1);
    chk(dout_en && dout == 8'h50, "R5 verify ce low", dout, 8'h50);
    set_ctl(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_quiet_modes();
    @(negedge clk);
    addr = 10'd3;
    set_ctl(1'b1, 1'b0, 1'b0);
    chk(!dout_en && dout == 8'h00, "R1 standby", {dout_en, dout}, 0);
    set_ctl(1'b0, 1'b1, 1'b0);
    chk(!dout_en && dout == 8'h00, "R1 output disable", {dout_en, dout}, 0);
    set_ctl(1'b1, 1'b1, 1'b1);
    chk(!dout_en && dout == 8'h00, "R1 program inhibit", {dout_en, dout}, 0);
    set_ctl(1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_inhibit();
    logic [7:0] d; logic e;
    @(negedge clk);
    addr = 10'd7; din = 8'h00; hv_on = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
    hv_on = 1'b0;
    rd(10'd7, 1'b0, d, e);
    chk(d == 8'hFF, "R6 inhibit keeps byte", d, 8'hFF);
  endtask

  task automatic t_signature();
    logic [7:0] d; logic e;
    prog(10'd0, 8'h11, 1);
    rd(10'd0, 1'b1, d, e);
    chk(e && d == 8'h8F, "R7 maker code", d, 8'h8F);
    rd(10'd1, 1'b1, d, e);
    chk(e && d == 8'h08, "R7 device code", d, 8'h08);
    rd(10'd0, 1'b0, d, e);
    chk(d == 8'h11, "R7 array behind signature", d, 8'h11);
  endtask

  task automatic t_erase();
    logic [7:0] d; logic e;
    @(negedge clk);
    erase = 1'b1;
    @(negedge clk);
    erase = 1'b0;
    rd(10'd3, 1'b0, d, e);
    chk(d == 8'hFF, "R2 erase addr 3", d, 8'hFF);
    rd(10'd0, 1'b0, d, e);
    chk(d == 8'hFF, "R4 erase restores ones", d, 8'hFF);
  endtask

  task automatic t_hv_rise();
    logic [7:0] d; logic e;
    do_reset();
    @(negedge clk);
    addr = 10'd9; din = 8'h00; oe_n = 1'b1; ce_n = 1'b0; hv_on = 1'b0;
    repeat (2) @(negedge clk);
    hv_on = 1'b1;
    repeat (3) @(negedge clk);
    ce_n = 1'b1;
    repeat (2) @(negedge clk);
    hv_on = 1'b0;
    chk(err == 1'b1, "R8 supply rise under low strobe", err, 1);
    rd(10'd9, 1'b0, d, e);
    chk(d == 8'hFF, "R8 no write", d, 8'hFF);
    repeat (10) @(negedge clk);
    chk(err == 1'b1, "R10 error held", err, 1);
    do_reset();
    chk(err == 1'b0, "R10 reset clears", err, 0);
  endtask

  task automatic t_width();
    logic [7:0] d; logic e;
    prog(10'd11, 8'h0F, PW);
    chk(err == 1'b0, "R9 max width accepted", err, 0);
    rd(10'd11, 1'b0, d, e);
    chk(d == 8'h0F, "R9 max width writes", d, 8'h0F);
    prog(10'd12, 8'h00, PW + 1);
    chk(err == 1'b1, "R9 overlong flagged", err, 1);
    rd(10'd12, 1'b0, d, e);
    chk(d == 8'hFF, "R9 overlong no write", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_blank();
    t_program_and();
    t_latency();
    t_verify();
    t_quiet_modes();
    t_inhibit();
    t_signature();
    t_erase();
    t_hv_rise();
    t_width();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule